// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block guesses, during instruction fetch, whether a branch will be taken and where it goes. The fetch PC is presented on the lookup port, and in the same cycle the block returns a predicted direction, a flag saying whether the target cache holds this branch, and the cached target. The fetch unit redirects to that target when the direction is taken and the flag is set. A wrong guess costs only cycles, never correctness: the pipeline flushes the wrong-path work and restarts on its own. This block is not involved in that flush.

Direction state sits in an untagged, direct-mapped table indexed by PC bits above the byte offset. A parameter picks one of two schemes. The first is one bit per entry that flips whenever the branch was mispredicted. The second is a two-bit saturating counter, which needs two wrong outcomes in a row before it changes its guess. Taken targets are held in a separate direct-mapped buffer. Each entry has a partial-PC tag and a valid bit. When a branch resolves, the back end reports it on the update port, which writes both structures at the next clock edge.

Top module: `branch_predictor`

## Requirements
- R1: Synchronous reset makes every entry predict not-taken (counters set to 1, single bits set to 0), clears every target valid bit, and so drives lk_taken=0, lk_hit=0 and lk_target=0 for any PC.
- R2: The direction entry is selected by PC bits [DIR_IDX_W+1:2] and has no tag, so PCs that match in those bits share one prediction.
- R3: With SCHEME_BITS=1, an update that has up_mispredict=1 inverts the entry's bit. An update with up_mispredict=0 leaves the bit alone, and up_taken has no effect on the direction bit.
- R4: With SCHEME_BITS=2, each update moves the counter up by one on taken, saturating at 3, or down by one on not-taken, saturating at 0. Counter values 2 and 3 predict taken, and up_mispredict has no effect.
- R5: In two-bit mode, a counter at a strong value (0 or 3) keeps its prediction after one opposite outcome and changes it only after a second one in a row.
- R6: The target buffer is written only by an update with up_taken=1. That write sets the entry valid and stores tag PC[BTB_IDX_W+TAG_W+1:BTB_IDX_W+2] and the target, at index PC[BTB_IDX_W+1:2]. A not-taken update leaves the buffer unchanged.
- R7: lk_hit is 1 only when the indexed target entry is valid and its tag equals the lookup PC's tag bits. On a miss, lk_target is 0.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the state held before that update. The write becomes visible from the next cycle.
- R9: A cycle with up_valid=0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hit | output | 1 | Target buffer holds this PC |
| lk_target | output | PC_W | Cached taken target, 0 on miss |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_target | input | PC_W | Actual taken target |
| up_mispredict | input | 1 | The earlier prediction was wrong |

## Verification
Two instances, one per scheme, receive the same stimulus so that their direction outputs can be compared against separate models. Directed runs of repeated taken outcomes followed by one exit separate the one-bit flip from two-bit hysteresis. PCs that differ only above the direction index show that the direction state is shared while the target tag misses. Lookups made in the same cycle as an update to the same PC confirm that the old value is returned. Random traffic uses a narrow PC range and sets the mispredict flag independently of the outcome, so that entries collide often. This exercises the flag being ignored in two-bit mode and up_taken being ignored in one-bit mode.

// File: rtl/bp_pkg.sv
package bp_pkg;

   // Two-bit direction counter states; the upper bit is the guess.
   typedef enum logic [1:0] {
      CTR_SNT = 2'd0,
      CTR_WNT = 2'd1,
      CTR_WT  = 2'd2,
      CTR_ST  = 2'd3
   } ctr_state_e;

   localparam int unsigned BYTE_OFS_W = 2;

   function automatic ctr_state_e ctr_step(input ctr_state_e cur, input logic taken);
      ctr_state_e nxt;
      nxt = cur;
      if (taken) begin
         if (cur != CTR_ST) nxt = ctr_state_e'(cur + 2'd1);
      end else begin
         if (cur != CTR_SNT) nxt = ctr_state_e'(cur - 2'd1);
      end
      return nxt;
   endfunction

   function automatic logic ctr_guess(input ctr_state_e cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bp_index_split.sv
module bp_index_split #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned DIR_IDX_W = 6,
   parameter int unsigned BTB_IDX_W = 4,
   parameter int unsigned TAG_W     = 8
) (
   input  logic [PC_W-1:0]      pc,
   output logic [DIR_IDX_W-1:0] dir_idx,
   output logic [BTB_IDX_W-1:0] btb_idx,
   output logic [TAG_W-1:0]     btb_tag
);
   import bp_pkg::*;

   localparam int unsigned TAG_LSB = BYTE_OFS_W + BTB_IDX_W;

   assign dir_idx = pc[BYTE_OFS_W +: DIR_IDX_W];
   assign btb_idx = pc[BYTE_OFS_W +: BTB_IDX_W];
   assign btb_tag = pc[TAG_LSB +: TAG_W];

   logic unused_pc_bits;
   assign unused_pc_bits = ^pc;

endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
   parameter int unsigned IDX_W       = 6,
   parameter int unsigned SCHEME_BITS = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken,
   input  logic             wr_mispredict
);
   import bp_pkg::*;

   localparam int unsigned DEPTH = 1 << IDX_W;

   generate
      if (SCHEME_BITS == 1) begin : g_one_bit
         logic last_q [DEPTH];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) last_q[i] <= 1'b0;
            end else if (wr_en && wr_mispredict) begin
               last_q[wr_idx] <= ~last_q[wr_idx];
            end
         end

         assign rd_taken = last_q[rd_idx];

         logic unused_taken;
         assign unused_taken = wr_taken;
      end else begin : g_two_bit
         ctr_state_e ctr_q [DEPTH];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WNT;
            end else if (wr_en) begin
               ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
            end
         end

         assign rd_taken = ctr_guess(ctr_q[rd_idx]);

         logic unused_mispredict;
         assign unused_mispredict = wr_mispredict;
      end
   endgenerate

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [PC_W-1:0]  rd_target,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_target
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic             vld_q [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [PC_W-1:0]  tgt_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   // Payload needs no reset: it is qualified by the valid bit.
   always_ff @(posedge clk) begin
      if (!rst && wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_target;
      end
   end

   always_comb begin
      rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
      rd_target = rd_hit ? tgt_q[rd_idx] : '0;
   end

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned DIR_IDX_W   = 6,
   parameter int unsigned BTB_IDX_W   = 4,
   parameter int unsigned TAG_W       = 8,
   parameter int unsigned SCHEME_BITS = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   output logic            lk_hit,
   output logic [PC_W-1:0] lk_target,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   input  logic [PC_W-1:0] up_target,
   input  logic            up_mispredict
);
   import bp_pkg::*;

   generate
      if (SCHEME_BITS != 1 && SCHEME_BITS != 2) begin : g_bad_scheme
         $error("SCHEME_BITS must be 1 or 2");
      end
      if (DIR_IDX_W + BYTE_OFS_W > PC_W || DIR_IDX_W < 1) begin : g_bad_dir
         $error("direction index does not fit in the PC");
      end
      if (BTB_IDX_W + TAG_W + BYTE_OFS_W > PC_W || BTB_IDX_W < 1 || TAG_W < 1) begin : g_bad_btb
         $error("target index and tag do not fit in the PC");
      end
   endgenerate

   logic [DIR_IDX_W-1:0] lk_dir_idx, up_dir_idx;
   logic [BTB_IDX_W-1:0] lk_btb_idx, up_btb_idx;
   logic [TAG_W-1:0]     lk_tag, up_tag;

   bp_index_split #(
      .PC_W(PC_W), .DIR_IDX_W(DIR_IDX_W), .BTB_IDX_W(BTB_IDX_W), .TAG_W(TAG_W)
   ) u_lk_split (
      .pc(lk_pc), .dir_idx(lk_dir_idx), .btb_idx(lk_btb_idx), .btb_tag(lk_tag)
   );

   bp_index_split #(
      .PC_W(PC_W), .DIR_IDX_W(DIR_IDX_W), .BTB_IDX_W(BTB_IDX_W), .TAG_W(TAG_W)
   ) u_up_split (
      .pc(up_pc), .dir_idx(up_dir_idx), .btb_idx(up_btb_idx), .btb_tag(up_tag)
   );

   bp_dir_table #(
      .IDX_W(DIR_IDX_W), .SCHEME_BITS(SCHEME_BITS)
   ) u_dir (
      .clk(clk), .rst(rst),
      .rd_idx(lk_dir_idx), .rd_taken(lk_taken),
      .wr_en(up_valid), .wr_idx(up_dir_idx),
      .wr_taken(up_taken), .wr_mispredict(up_mispredict)
   );

   bp_target_buf #(
      .PC_W(PC_W), .IDX_W(BTB_IDX_W), .TAG_W(TAG_W)
   ) u_btb (
      .clk(clk), .rst(rst),
      .rd_idx(lk_btb_idx), .rd_tag(lk_tag),
      .rd_hit(lk_hit), .rd_target(lk_target),
      .wr_en(up_valid && up_taken), .wr_idx(up_btb_idx),
      .wr_tag(up_tag), .wr_target(up_target)
   );

endmodule

// File: rtl/branch_predictor_chk.sv
module branch_predictor_chk #(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned SCHEME_BITS = 2
) (
   input logic            clk,
   input logic            rst,
   input logic [PC_W-1:0] lk_pc,
   input logic            lk_taken,
   input logic            lk_hit,
   input logic [PC_W-1:0] lk_target,
   input logic            up_valid,
   input logic [PC_W-1:0] up_pc,
   input logic            up_taken,
   input logic [PC_W-1:0] up_target,
   input logic            up_mispredict
);

   // R1
   reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!lk_taken && !lk_hit && lk_target == '0));

   // R6
   taken_fills_target_chk: assert property (@(posedge clk) disable iff (rst)
      (up_valid && up_taken) |=>
         (lk_pc != $past(up_pc)) || (lk_hit && lk_target == $past(up_target)));

   // R7
   miss_zero_target_chk: assert property (@(posedge clk) disable iff (rst)
      !lk_hit |-> lk_target == '0);

   // R9
   idle_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
      !up_valid |=> (lk_pc != $past(lk_pc)) ||
         (lk_taken == $past(lk_taken) && lk_hit == $past(lk_hit) &&
          lk_target == $past(lk_target)));

   generate
      if (SCHEME_BITS == 1) begin : g_one
         // R3
         flip_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
            (up_valid && up_mispredict && lk_pc == up_pc) |=>
               (lk_pc != $past(lk_pc)) || (lk_taken != $past(lk_taken)));
         // R3
         keep_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
            (up_valid && !up_mispredict && lk_pc == up_pc) |=>
               (lk_pc != $past(lk_pc)) || (lk_taken == $past(lk_taken)));
      end else begin : g_two
         // R4
         taken_stays_taken_chk: assert property (@(posedge clk) disable iff (rst)
            (up_valid && up_taken && lk_taken && lk_pc == up_pc) |=>
               (lk_pc != $past(lk_pc)) || lk_taken);
         // R4
         nt_stays_nt_chk: assert property (@(posedge clk) disable iff (rst)
            (up_valid && !up_taken && !lk_taken && lk_pc == up_pc) |=>
               (lk_pc != $past(lk_pc)) || !lk_taken);
      end
   endgenerate

endmodule

bind branch_predictor branch_predictor_chk #(
   .PC_W(PC_W), .SCHEME_BITS(SCHEME_BITS)
) u_chk (
   .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hit(lk_hit),
   .lk_target(lk_target), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
   .up_target(up_target), .up_mispredict(up_mispredict)
);

// File: tb/branch_predictor_tb.sv
`timescale 1ns/1ps
module branch_predictor_tb;
   localparam int PC_W = 32;
   localparam int DIR_N = 64;   // DIR_IDX_W = 6
   localparam int BTB_N = 16;   // BTB_IDX_W = 4

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [PC_W-1:0] lk_pc = '0;
   logic [PC_W-1:0] up_pc = '0;
   logic [PC_W-1:0] up_target = '0;
   logic            up_valid = 1'b0, up_taken = 1'b0, up_mispredict = 1'b0;
   logic            t2, h2, t1, h1;
   logic [PC_W-1:0] g2, g1;

   always #10 clk = ~clk;   // 50 MHz

   branch_predictor #(.SCHEME_BITS(2)) u_dut (
      .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(t2), .lk_hit(h2), .lk_target(g2),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_target(up_target), .up_mispredict(up_mispredict));

   branch_predictor #(.SCHEME_BITS(1)) u_dut_1b (
      .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(t1), .lk_hit(h1), .lk_target(g1),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_target(up_target), .up_mispredict(up_mispredict));

   // Reference state
   int unsigned     m_ctr [DIR_N];
   logic            m_bit [DIR_N];
   logic            m_vld [BTB_N];
   logic [7:0]      m_tag [BTB_N];
   logic [PC_W-1:0] m_tgt [BTB_N];

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   function automatic int didx(input logic [PC_W-1:0] pc); return int'(pc[7:2]); endfunction
   function automatic int bidx(input logic [PC_W-1:0] pc); return int'(pc[5:2]); endfunction
   function automatic logic [7:0] btag(input logic [PC_W-1:0] pc); return pc[13:6]; endfunction
   function automatic logic exp_hit(input logic [PC_W-1:0] pc);
      return m_vld[bidx(pc)] && m_tag[bidx(pc)] == btag(pc);
   endfunction
   function automatic logic [PC_W-1:0] exp_tgt(input logic [PC_W-1:0] pc);
      return exp_hit(pc) ? m_tgt[bidx(pc)] : '0;
   endfunction

   task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (pc %0h)", req, act, exp, lk_pc);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < DIR_N; i++) begin m_ctr[i] = 1; m_bit[i] = 1'b0; end
      for (int i = 0; i < BTB_N; i++) m_vld[i] = 1'b0;
   endtask

   task automatic step(input logic [PC_W-1:0] lpc, input logic uv, input logic [PC_W-1:0] upc,
                       input logic ut, input logic [PC_W-1:0] utg, input logic um, input string req);
      @(negedge clk);
      lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg; up_mispredict = um;
      #2;
      chk({req, " two-bit dir"}, {31'd0, t2}, {31'd0, m_ctr[didx(lpc)] >= 2});
      chk({req, " one-bit dir"}, {31'd0, t1}, {31'd0, m_bit[didx(lpc)]});
      chk({req, " hit"}, {30'd0, h2, h1}, {30'd0, exp_hit(lpc), exp_hit(lpc)});
      chk({req, " target"}, g2, exp_tgt(lpc));
      chk({req, " target 1b"}, g1, exp_tgt(lpc));
      @(posedge clk);
      if (uv) begin
         if (ut && m_ctr[didx(upc)] < 3) m_ctr[didx(upc)]++;
         if (!ut && m_ctr[didx(upc)] > 0) m_ctr[didx(upc)]--;
         if (um) m_bit[didx(upc)] = ~m_bit[didx(upc)];
         if (ut) begin
            m_vld[bidx(upc)] = 1'b1; m_tag[bidx(upc)] = btag(upc); m_tgt[bidx(upc)] = utg;
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic [PC_W-1:0] pa, pb;
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R1: reset state everywhere sampled
      for (int i = 0; i < 8; i++) step(32'h40 * i + 4 * i, 0, 0, 0, 0, 0, "R1 reset");

      pa = 32'h0000_0100;
      // R4 counter climbs 1->2->3->3; R8 same-cycle lookup sees old value
      step(pa, 1, pa, 1, 32'h8000, 0, "R8 collision");
      step(pa, 1, pa, 1, 32'h8000, 0, "R4 climb");
      step(pa, 1, pa, 1, 32'h8000, 1, "R4 saturate, mispredict ignored");
      step(pa, 1, pa, 0, 32'h0, 1, "R5 strong taken one exit");
      step(pa, 0, 0, 0, 0, 0, "R5 still taken after one miss");
      step(pa, 1, pa, 0, 32'h0, 0, "R3 one-bit no flip without mispredict");
      step(pa, 0, 0, 0, 0, 0, "R5 flips after second miss");
      // R2 alias above the index: shared direction; R7 tag miss
      step(pa + 32'h100, 0, 0, 0, 0, 0, "R2 alias shares direction / R7 tag miss");
      step(pa + 32'h100, 1, pa + 32'h100, 1, 32'h9000, 1, "R2 alias update");
      step(pa, 0, 0, 0, 0, 0, "R2 original sees alias update / R7 tag replaced");
      // R6 not-taken update does not fill target buffer
      pb = 32'h0000_2024;
      step(pb, 1, pb, 0, 32'hDEAD, 1, "R6 not-taken no fill");
      step(pb, 0, 0, 0, 0, 0, "R6 still miss");
      // R9 idle cycles
      for (int i = 0; i < 4; i++) step(pa, 0, pa, 1, 32'h1234, 1, "R9 idle ignores update fields");

      // Random mix over a small PC space to force collisions
      for (int i = 0; i < 4000; i++) begin
         logic [PC_W-1:0] rp, up;
         rp = ($urandom_range(0, 2047)) << 2;
         up = ($urandom_range(0, 3) == 0) ? rp : (($urandom_range(0, 2047)) << 2);
         step(rp, $urandom_range(0, 3) != 0, up, $urandom_range(0, 1) == 1,
              $urandom, $urandom_range(0, 1) == 1, "R3 R4 R6 R7 R8 random");
      end

      // R1 again after mid-run reset
      @(negedge clk); rst = 1'b1; up_valid = 1'b0;
      @(posedge clk); model_reset();
      @(negedge clk); rst = 1'b0;
      for (int i = 0; i < 4; i++) step(pa + 4 * i, 0, 0, 0, 0, 0, "R1 re-reset");
      finish_run();
   end
endmodule